// File: doc/BRIEF.md
# Predicated Vector Floating-Point Exponent Extractor

This block takes a 256-bit vector of IEEE floating-point elements and returns, for every enabled lane, the unbiased base-2 exponent of that element. The exponent is a two's-complement signed integer as wide as the element. A 2-bit size select picks half, single or double precision, which gives 16, 8 or 4 lanes. Subnormal inputs get their exact exponent from a leading-zero count of the fraction. Infinities, zeros and NaNs produce fixed saturated sentinel values and raise no exception.

A single-cycle start strobe launches an operation. The result register is updated on the next clock edge and a done flag pulses for one cycle. The result register also acts as the destination: a lane whose predicate bit is clear keeps the value it already holds. A size select of 00 is not a legal encoding. In that case the block flags the request and leaves the destination untouched.

Top module: `vec_logb_unit`

## Requirements
- R1: For a normal element (exponent field neither all zeros nor all ones) the lane result is the exponent field minus the bias. Half precision has 5 exponent bits at [14:10] with bias 15. Single has 8 bits at [30:23] with bias 127. Double has 11 bits at [62:52] with bias 1023.
- R2: An infinity (exponent all ones, fraction zero) of either sign gives the largest positive signed integer of the element width.
- R3: A zero of either sign, and any NaN (exponent all ones, fraction nonzero), give the most negative signed integer of the element width.
- R4: A subnormal element (exponent zero, fraction nonzero) gives minus the bias minus the count of leading zeros in its fraction field of 10, 23 or 52 bits. A set top fraction bit therefore yields exactly -15, -127 or -1023, and a fraction of 1 yields -24, -149 or -1074.
- R5: For any finite nonzero element, the sign bit (the element's top bit) has no effect on the result.
- R6: size_i = 01, 10 and 11 select 16-, 32- and 64-bit elements. Element i occupies bits [i*W +: W] of both the operand and the result.
- R7: Lane i is active when pred_i bit i*W/8 is set, that is, the bit of the element's lowest byte. An inactive lane keeps its previous result_o value.
- R8: result_o and illegal_o change only on the clock edge that samples start_i high. done_o is high in exactly the cycle after each sampled start.
- R9: A start with size_i = 00 sets illegal_o together with done_o for that one cycle and leaves result_o unchanged. A start with a legal size clears illegal_o.
- R10: Synchronous active-low reset clears result_o, done_o and illegal_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | One-cycle operation strobe |
| size_i | input | 2 | Element size select, sampled with start_i |
| opnd_i | input | 256 | Floating-point operand vector |
| pred_i | input | 32 | Per-byte governing predicate |
| result_o | output | 256 | Exponent result / destination vector |
| done_o | output | 1 | Operation complete pulse |
| illegal_o | output | 1 | Illegal size encoding flag, valid with done_o |

## Verification
Every result of this block is due one clock edge after the start strobe that requested it. That applies to the lane exponents, the merged lanes, the done pulse and the illegal flag, and in idle cycles result_o must stay unchanged. The bench keeps a behavioural model that it advances on each rising edge from the same inputs as the design. It compares all three outputs against this model at every falling edge, so each value is checked in the cycle it is due and in every later cycle until the next start.

// File: rtl/logb_pkg.sv
// Package: shared element-size encoding for the exponent-extraction unit.
// Assumes: code 0 is reserved and illegal; codes 1..3 are 16/32/64-bit elements.
package logb_pkg;
    typedef enum logic [1:0] {
        ESZ_BAD  = 2'd0,
        ESZ_HALF = 2'd1,
        ESZ_SGL  = 2'd2,
        ESZ_DBL  = 2'd3
    } esz_e;

    localparam int unsigned NUM_SIZES = 3;
endpackage

// File: rtl/lead_zero_cnt.sv
// Module: counts leading zeros of a vector, MSB first.
// Assumes: an all-zero input returns IN_W; purely combinational.
module lead_zero_cnt #(
    parameter int unsigned IN_W  = 10,
    localparam int unsigned CNT_W = $clog2(IN_W + 1)
) (
    input  logic [IN_W-1:0]  vec_i,
    output logic [CNT_W-1:0] cnt_o
);
    // Scan upward so the highest set bit determines the count.
    always_comb begin
        cnt_o = CNT_W'(IN_W);
        for (int i = 0; i < int'(IN_W); i++) begin
            if (vec_i[i]) cnt_o = CNT_W'(int'(IN_W) - 1 - i);
        end
    end
endmodule

// File: rtl/logb_lane.sv
// Module: one lane; classifies an IEEE element of width W and returns its
// unbiased exponent as a W-bit two's-complement integer.
// Assumes: W is 16, 32 or 64; exponent sits just below the sign bit.
module logb_lane #(
    parameter int unsigned W = 16,
    localparam int unsigned EXP_W  = (W == 16) ? 5 : (W == 32) ? 8 : 11,
    localparam int unsigned FRAC_W = W - 1 - EXP_W,
    localparam int unsigned BIAS   = (1 << (EXP_W - 1)) - 1,
    localparam int unsigned CNT_W  = $clog2(FRAC_W + 1)
) (
    input  logic [W-1:0] elem_i,
    output logic [W-1:0] logb_o
);
    logic [EXP_W-1:0]  exp_f;
    logic [FRAC_W-1:0] frac_f;
    logic [CNT_W-1:0]  lz;
    logic [W-1:0]      int_max, int_min;

    assign exp_f   = elem_i[W-2 -: EXP_W];
    assign frac_f  = elem_i[FRAC_W-1:0];
    assign int_min = {1'b1, {(W-1){1'b0}}};
    assign int_max = {1'b0, {(W-1){1'b1}}};

    lead_zero_cnt #(.IN_W(FRAC_W)) lzc_i (
        .vec_i (frac_f),
        .cnt_o (lz)
    );

    // Select the sentinel or computed exponent from the element class.
    always_comb begin
        if (&exp_f) begin
            logb_o = (frac_f == '0) ? int_max : int_min;
        end else if (exp_f == '0) begin
            if (frac_f == '0) logb_o = int_min;
            else              logb_o = '0 - W'(BIAS) - W'(lz);
        end else begin
            logb_o = W'(exp_f) - W'(BIAS);
        end
    end
endmodule

// File: rtl/vec_logb_unit.sv
// Module: predicated vector exponent extractor, 16/32/64-bit elements.
// Computes all three element-size variants in parallel, merges inactive
// lanes with the held result, and registers the chosen variant on start.
// Assumes: start_i is a one-cycle strobe; size_i is valid with start_i.
module vec_logb_unit
    import logb_pkg::*;
#(
    parameter int unsigned DATA_W = 256,
    localparam int unsigned PRED_W = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [1:0]        size_i,
    input  logic [DATA_W-1:0] opnd_i,
    input  logic [PRED_W-1:0] pred_i,
    output logic [DATA_W-1:0] result_o,
    output logic              done_o,
    output logic              illegal_o
);
    logic [DATA_W-1:0] cand [NUM_SIZES];
    logic [DATA_W-1:0] result_q;
    logic              done_q, illegal_q;
    logic [DATA_W-1:0] next_res;
    esz_e              esz;

    assign esz = esz_e'(size_i);

    for (genvar sz = 0; sz < int'(NUM_SIZES); sz++) begin : g_size
        localparam int unsigned EW    = 16 << sz;
        localparam int unsigned LANES = DATA_W / EW;
        for (genvar l = 0; l < int'(LANES); l++) begin : g_lane
            logic [EW-1:0] lane_res;
            logb_lane #(.W(EW)) lane_i (
                .elem_i (opnd_i[l*EW +: EW]),
                .logb_o (lane_res)
            );
            // Merge: active lanes take the new exponent, others hold.
            assign cand[sz][l*EW +: EW] =
                pred_i[l*(EW/8)] ? lane_res : result_q[l*EW +: EW];
        end
    end

    // Pick the candidate vector for the requested element size.
    always_comb begin
        unique case (esz)
            ESZ_HALF: next_res = cand[0];
            ESZ_SGL:  next_res = cand[1];
            ESZ_DBL:  next_res = cand[2];
            default:  next_res = result_q;
        endcase
    end

    // Result register; updated only by a legal start.
    always_ff @(posedge clk) begin
        if (!rst_n)                          result_q <= '0;
        else if (start_i && esz != ESZ_BAD)  result_q <= next_res;
    end

    // Completion and illegal-encoding flags for one cycle after start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q    <= 1'b0;
            illegal_q <= 1'b0;
        end else begin
            done_q    <= start_i;
            illegal_q <= start_i && (esz == ESZ_BAD);
        end
    end

    assign result_o  = result_q;
    assign done_o    = done_q;
    assign illegal_o = illegal_q;

    assert_done_follows_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> done_o);
    assert_no_spurious_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !start_i |=> !done_o);
    assert_idle_holds_result_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !start_i |=> $stable(result_o));
    assert_bad_size_flagged_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && size_i == 2'b00) |=> (illegal_o && done_o && $stable(result_o)));
    assert_good_size_clean_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && size_i != 2'b00) |=> !illegal_o);
    assert_illegal_only_with_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_o |-> done_o);
    assert_pred_off_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && size_i == 2'b11 && !pred_i[0]) |=> $stable(result_o[63:0]));
endmodule

// File: tb/vec_logb_unit_tb_top.sv
module vec_logb_unit_tb_top;
    localparam int DW = 256;
    localparam int PW = DW / 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic [1:0]    size_i = 2'b00;
    logic [DW-1:0] opnd_i = '0;
    logic [PW-1:0] pred_i = '0;
    logic [DW-1:0] result_o;
    logic          done_o, illegal_o;

    always #4 clk = ~clk;

    vec_logb_unit dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .size_i(size_i),
        .opnd_i(opnd_i), .pred_i(pred_i),
        .result_o(result_o), .done_o(done_o), .illegal_o(illegal_o)
    );

    int    n_cmp = 0;
    int    n_bad = 0;
    bit    cmp_en = 1'b0;
    bit    finished = 1'b0;
    string tag = "R10";

    logic [DW-1:0] m_res;
    logic          m_done, m_ill;

    // Behavioural exponent of one element of width w.
    function automatic logic [63:0] ref_logb(input logic [63:0] x, input int w);
        int ew, fw, bias, e, p;
        logic [63:0] frac, mn;
        ew   = (w == 16) ? 5 : (w == 32) ? 8 : 11;
        fw   = w - 1 - ew;
        bias = (1 << (ew - 1)) - 1;
        e    = int'((x >> fw) & ((64'd1 << ew) - 1));
        frac = x & ((64'd1 << fw) - 1);
        mn   = 64'd1 << (w - 1);
        if (e == (1 << ew) - 1) return (frac == 0) ? mn - 1 : mn;
        if (e == 0) begin
            if (frac == 0) return mn;
            p = 0;
            for (int b = 0; b < fw; b++) if (frac[b]) p = b;
            return 64'(-bias - (fw - 1 - p));
        end
        return 64'(e - bias);
    endfunction

    // Reference model, advanced on every rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_res  <= '0;
            m_done <= 1'b0;
            m_ill  <= 1'b0;
        end else begin
            m_done <= start_i;
            m_ill  <= start_i && size_i == 2'b00;
            if (start_i && size_i != 2'b00) begin
                automatic int w = 8 << size_i;
                automatic logic [DW-1:0] nr = m_res;
                for (int i = 0; i < DW / w; i++) begin
                    if (pred_i[i * w / 8]) begin
                        automatic logic [63:0] el = '0;
                        automatic logic [63:0] v;
                        for (int b = 0; b < w; b++) el[b] = opnd_i[i*w + b];
                        v = ref_logb(el, w);
                        for (int b = 0; b < w; b++) nr[i*w + b] = v[b];
                    end
                end
                m_res <= nr;
            end
        end
    end

    // Compare on every falling edge.
    always @(negedge clk) begin
        if (cmp_en && !finished) begin
            n_cmp++;
            if (result_o !== m_res || done_o !== m_done || illegal_o !== m_ill) begin
                n_bad++;
                $display("FAIL %s: got res=%h done=%b ill=%b exp res=%h done=%b ill=%b",
                         tag, result_o, done_o, illegal_o, m_res, m_done, m_ill);
            end
        end
    end

    task automatic set_lane(input int w, input int idx, input logic [63:0] v);
        for (int b = 0; b < w; b++) opnd_i[idx*w + b] = v[b];
    endtask

    task automatic fire(input string t, input logic [1:0] sz, input logic [PW-1:0] p);
        @(negedge clk);
        tag     = t;
        size_i  = sz;
        pred_i  = p;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        @(negedge clk);
    endtask

    task automatic fill(input int w, input logic [63:0] v);
        for (int i = 0; i < DW / w; i++) set_lane(w, i, v);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        cmp_en = 1'b1;
        @(negedge clk);
        rst_n = 1'b1;
        tag = "R10";
        repeat (2) @(negedge clk);

        // R1 and R6: normals in each size, varied per lane
        for (int i = 0; i < 16; i++) set_lane(16, i, 64'(16'h0400 + i * 16'h0c00 + i));
        fire("R1", 2'b01, '1);
        for (int i = 0; i < 8; i++) set_lane(32, i, 64'(32'h3f80_0000 + i * 32'h0f00_0000));
        fire("R1", 2'b10, '1);
        for (int i = 0; i < 4; i++) set_lane(64, i, 64'h3ff0_0000_0000_0001 + 64'(i) * 64'h1230_0000_0000_0000);
        fire("R6", 2'b11, '1);
        set_lane(64, 0, 64'h7fef_ffff_ffff_ffff); set_lane(64, 1, 64'h0010_0000_0000_0000);
        fire("R1", 2'b11, '1);

        // R2: infinities of both signs
        fill(16, 64'h7c00); set_lane(16, 3, 64'hfc00);
        fire("R2", 2'b01, '1);
        fill(32, 64'hff80_0000);
        fire("R2", 2'b10, '1);
        fill(64, 64'h7ff0_0000_0000_0000);
        fire("R2", 2'b11, '1);

        // R3: zeros and NaNs
        fill(32, 64'h8000_0000); set_lane(32, 1, 64'h7fc0_0000); set_lane(32, 2, 64'h7f80_0001);
        fire("R3", 2'b10, '1);
        fill(64, 64'h0); set_lane(64, 2, 64'hfff8_0000_0000_0000);
        fire("R3", 2'b11, '1);
        fill(16, 64'h7e00); set_lane(16, 0, 64'h0000);
        fire("R3", 2'b01, '1);

        // R4: subnormals, top fraction bit set and fraction of one
        for (int i = 0; i < 16; i++) set_lane(16, i, 64'(16'h0200 >> (i % 10)));
        fire("R4", 2'b01, '1);
        for (int i = 0; i < 8; i++) set_lane(32, i, 64'(32'h0040_0000 >> (i * 3)));
        set_lane(32, 7, 64'h1);
        fire("R4", 2'b10, '1);
        set_lane(64, 0, 64'h0008_0000_0000_0000); set_lane(64, 1, 64'h1);
        set_lane(64, 2, 64'h0000_0000_8000_0000); set_lane(64, 3, 64'h0004_0000_0000_0000);
        fire("R4", 2'b11, '1);

        // R5: negative finite values
        for (int i = 0; i < 8; i++) set_lane(32, i, 64'(32'hc120_0000 + i * 32'h0080_0000));
        set_lane(32, 5, 64'h8000_0003);
        fire("R5", 2'b10, '1);
        fill(16, 64'hbc00); set_lane(16, 9, 64'h8001);
        fire("R5", 2'b01, '1);

        // R7: predicate patterns, lowest-byte bit only counts
        fill(16, 64'h5000);
        fire("R7", 2'b01, 32'h5555_5554);
        fill(64, 64'h4000_0000_0000_0000);
        fire("R7", 2'b11, 32'hfefe_0100);
        fill(32, 64'h0);
        fire("R7", 2'b10, 32'h0000_0000);

        // R9: illegal size leaves result alone
        fill(16, 64'h3c00);
        fire("R9", 2'b00, '1);
        fire("R9", 2'b01, '1);

        // R8: back-to-back starts, then idle with changing inputs
        @(negedge clk);
        tag = "R8";
        fill(32, 64'h4000_0000); size_i = 2'b10; pred_i = '1; start_i = 1'b1;
        @(negedge clk);
        fill(32, 64'h5000_0000); size_i = 2'b00;
        @(negedge clk);
        size_i = 2'b11;
        @(negedge clk);
        start_i = 1'b0; fill(64, 64'h1234_5678_0000_0000);
        repeat (4) @(negedge clk);

        // R10: reset in the middle of held state
        tag = "R10";
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_bad++;
            $display("FAIL watchdog: got hung run exp completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule